// File: doc/BRIEF.md
# Sector Access Permission Decoder

This block decides whether a memory command against one block of a four-block sector may proceed. It takes the three protection bytes of the sector's trailer, the index of the block being addressed, the key that opened the session (A or B), and the requested operation. It returns a grant, a flag for a malformed protection word, and a flag that tells the session controller the sector's key B is exposed for reading and so must not be trusted as a credential.

Each block owns a three-bit protection code. Every bit of each code is stored twice in the trailer, once true and once inverted, and all twelve pairs are compared on every evaluation. Any pair that fails to differ marks the whole sector as corrupt, and every command is then refused. Data blocks and the trailer block are looked up in two separate eight-entry permission tables. The trailer table answers per trailer field: key A, the protection bytes, and key B.

The decision is combinational. A parameter selects whether it is presented straight away or through one output register.

Top module: `acd_gate`

## Requirements
- R1: `trl_acc` packs trailer bytes 6, 7 and 8 as bits [7:0], [15:8] and [23:16]. For block b (0 to 3) the code is {c1,c2,c3}, with c1 = bit 12+b, c2 = bit 16+b and c3 = bit 20+b. The inverted copies are ~c1 at bit b, ~c2 at bit 4+b and ~c3 at bit 8+b.
- R2: If any of the twelve true/inverted bit pairs is equal, `fmt_bad` is 1, and `grant` and `keyb_exposed` are 0 for every block, key and operation.
- R3: For blocks 0 to 2, operations are read (0), write (1), increment (2) and decrement/transfer/restore (3). Read is allowed with either key for 000, 001, 010, 100 and 110, with key B for 011 and 101, and never for 111. Write is allowed with either key for 000 and with key B for 011, 100 and 110. Increment is allowed with either key for 000 and with key B for 110. Decrement is allowed with either key for 000, 001 and 110. Every other case is denied.
- R4: On block 3, reading key A (op 4) is never granted. Writing key A (op 5) is granted with key A for codes 000 and 001, with key B for 011, and never otherwise.
- R5: On block 3, reading the protection bytes (op 6) is granted only with key A for codes 000, 001 and 010, and with either key for all other codes. Writing them (op 7) is granted with key A for 001, with key B for 011, and never otherwise.
- R6: On block 3, reading key B (op 8) is granted with key A for codes 000, 001 and 010, and never otherwise. Writing key B (op 9) is granted with key A for 000 and 001, with key B for 011 and 100, and never otherwise.
- R7: Operations 0 to 3 on block 3, operations 4 to 9 on blocks 0 to 2, and operation codes 10 to 15 on any block are never granted.
- R8: `keyb_exposed` is 1 when the word is well formed and the block 3 code is 000, 001 or 010. While it is 1, no command authenticated with key B is granted on any block.
- R9: The shipping word 24'h8007FF (bytes FF 07 80) is well formed. It decodes to code 000 on blocks 0 to 2 and to 001 on block 3.
- R10: With `REG_OUT`=1, outputs change only at a rising clock edge, one cycle after the inputs. While `rst_n` is low, all three outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| trl_acc | input | 24 | Trailer bytes 6..8 (byte 6 in the low bits) |
| blk_sel | input | 2 | Addressed block within the sector, 3 = trailer |
| auth_key_b | input | 1 | 1 = session opened with key B, 0 = key A |
| op_req | input | 4 | Requested operation code (0..9 used) |
| grant | output | 1 | Command permitted |
| fmt_bad | output | 1 | Protection bytes malformed |
| keyb_exposed | output | 1 | Key B readable, must not authenticate |

## Verification
The assertions check, on every cycle, the rules that hold whatever the protection bytes contain. A malformed word never yields a grant. Key A is never readable. Arithmetic never reaches the trailer, and trailer-field operations never reach data blocks. Key B sessions are refused while key B is exposed. The exact contents of both permission tables, the bit positions of each code, the shipping word, and the one-cycle output timing can only be shown by the bench's sweeps. The bench walks every code against every operation and both keys, flips each protection bit in turn, and compares against its reference model.

// File: rtl/acd_pkg.sv
package acd_pkg;

   localparam int unsigned CODE_W = 3;

   // Operation codes presented on op_req
   localparam logic [3:0] OP_RD    = 4'd0;
   localparam logic [3:0] OP_WR    = 4'd1;
   localparam logic [3:0] OP_INC   = 4'd2;
   localparam logic [3:0] OP_DEC   = 4'd3;
   localparam logic [3:0] OP_KA_RD = 4'd4;
   localparam logic [3:0] OP_KA_WR = 4'd5;
   localparam logic [3:0] OP_AC_RD = 4'd6;
   localparam logic [3:0] OP_AC_WR = 4'd7;
   localparam logic [3:0] OP_KB_RD = 4'd8;
   localparam logic [3:0] OP_KB_WR = 4'd9;

   // Which credentials unlock an action
   typedef struct packed {
      logic by_a;
      logic by_b;
   } perm_t;

   localparam perm_t P_NONE = '{by_a: 1'b0, by_b: 1'b0};
   localparam perm_t P_A    = '{by_a: 1'b1, by_b: 1'b0};
   localparam perm_t P_B    = '{by_a: 1'b0, by_b: 1'b1};
   localparam perm_t P_AB   = '{by_a: 1'b1, by_b: 1'b1};

   function automatic logic perm_hit(input perm_t p, input logic key_b);
      return key_b ? p.by_b : p.by_a;
   endfunction

endpackage

// File: rtl/acd_field_split.sv
module acd_field_split
   import acd_pkg::*;
#(
   parameter int unsigned BLK_N = 4,
   localparam int unsigned AC_W = BLK_N * 6
) (
   input  logic [AC_W-1:0]               acw,
   output logic [BLK_N-1:0][CODE_W-1:0]  code_o,
   output logic                          fmt_err_o
);

   logic [BLK_N-1:0] pair_bad;

   for (genvar b = 0; b < BLK_N; b++) begin : g_blk
      logic [CODE_W-1:0] true_bits;
      logic [CODE_W-1:0] inv_bits;
      assign true_bits = {acw[3*BLK_N+b], acw[4*BLK_N+b], acw[5*BLK_N+b]};
      assign inv_bits  = {acw[b], acw[BLK_N+b], acw[2*BLK_N+b]};
      assign code_o[b] = true_bits;
      // a healthy pair always differs
      assign pair_bad[b] = |(true_bits ~^ inv_bits);
   end

   assign fmt_err_o = |pair_bad;

endmodule

// File: rtl/acd_data_rules.sv
module acd_data_rules
   import acd_pkg::*;
(
   input  logic [CODE_W-1:0] code_i,
   input  logic [3:0]        op_i,
   input  logic              key_b_i,
   output logic              allow_o
);

   perm_t p_rd, p_wr, p_inc, p_dec;

   always_comb begin
      p_rd  = P_NONE;
      p_wr  = P_NONE;
      p_inc = P_NONE;
      p_dec = P_NONE;
      unique case (code_i)
         3'b000: begin p_rd = P_AB; p_wr = P_AB; p_inc = P_AB; p_dec = P_AB; end
         3'b010: begin p_rd = P_AB; end
         3'b100: begin p_rd = P_AB; p_wr = P_B; end
         3'b110: begin p_rd = P_AB; p_wr = P_B; p_inc = P_B; p_dec = P_AB; end
         3'b001: begin p_rd = P_AB; p_dec = P_AB; end
         3'b011: begin p_rd = P_B;  p_wr = P_B; end
         3'b101: begin p_rd = P_B; end
         3'b111: begin end
         default: begin end
      endcase
   end

   always_comb begin
      case (op_i)
         OP_RD:   allow_o = perm_hit(p_rd,  key_b_i);
         OP_WR:   allow_o = perm_hit(p_wr,  key_b_i);
         OP_INC:  allow_o = perm_hit(p_inc, key_b_i);
         OP_DEC:  allow_o = perm_hit(p_dec, key_b_i);
         default: allow_o = 1'b0;
      endcase
   end

endmodule

// File: rtl/acd_trailer_rules.sv
module acd_trailer_rules
   import acd_pkg::*;
(
   input  logic [CODE_W-1:0] code_i,
   input  logic [3:0]        op_i,
   input  logic              key_b_i,
   output logic              allow_o,
   output logic              kb_open_o
);

   perm_t p_ka_wr, p_ac_rd, p_ac_wr, p_kb_rd, p_kb_wr;

   always_comb begin
      p_ka_wr = P_NONE;
      p_ac_rd = P_AB;
      p_ac_wr = P_NONE;
      p_kb_rd = P_NONE;
      p_kb_wr = P_NONE;
      kb_open_o = 1'b0;
      unique case (code_i)
         3'b000: begin
            p_ka_wr = P_A; p_ac_rd = P_A; p_kb_rd = P_A; p_kb_wr = P_A;
            kb_open_o = 1'b1;
         end
         3'b010: begin
            p_ac_rd = P_A; p_kb_rd = P_A;
            kb_open_o = 1'b1;
         end
         3'b001: begin
            p_ka_wr = P_A; p_ac_rd = P_A; p_ac_wr = P_A;
            p_kb_rd = P_A; p_kb_wr = P_A;
            kb_open_o = 1'b1;
         end
         3'b011: begin p_ka_wr = P_B; p_ac_wr = P_B; p_kb_wr = P_B; end
         3'b100: begin p_kb_wr = P_B; end
         3'b101, 3'b110, 3'b111: begin end
         default: begin end
      endcase
   end

   always_comb begin
      case (op_i)
         OP_KA_WR: allow_o = perm_hit(p_ka_wr, key_b_i);
         OP_AC_RD: allow_o = perm_hit(p_ac_rd, key_b_i);
         OP_AC_WR: allow_o = perm_hit(p_ac_wr, key_b_i);
         OP_KB_RD: allow_o = perm_hit(p_kb_rd, key_b_i);
         OP_KB_WR: allow_o = perm_hit(p_kb_wr, key_b_i);
         default:  allow_o = 1'b0; // key A read and arithmetic never
      endcase
   end

endmodule

// File: rtl/acd_gate.sv
module acd_gate
   import acd_pkg::*;
#(
   parameter int unsigned BLK_N   = 4,
   parameter int unsigned OP_W    = 4,
   parameter bit          REG_OUT = 1'b1,
   localparam int unsigned AC_W    = BLK_N * 6,
   localparam int unsigned IDX_W   = $clog2(BLK_N),
   localparam int unsigned TRL_IDX = BLK_N - 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [AC_W-1:0]   trl_acc,
   input  logic [IDX_W-1:0]  blk_sel,
   input  logic              auth_key_b,
   input  logic [OP_W-1:0]   op_req,
   output logic              grant,
   output logic              fmt_bad,
   output logic              keyb_exposed
);

   if (BLK_N != 4) begin : g_bad_blk
      $error("acd_gate: sector must hold exactly four blocks");
   end
   if (OP_W != 4) begin : g_bad_op
      $error("acd_gate: operation code must be four bits wide");
   end

   logic [BLK_N-1:0][CODE_W-1:0] code_all;
   logic                         fmt_err;
   logic [CODE_W-1:0]            code_sel;
   logic                         dat_ok, trl_ok, kb_open;
   logic                         is_trl;
   logic                         grant_c, kbx_c;

   acd_field_split #(.BLK_N(BLK_N)) i_split (
      .acw       (trl_acc),
      .code_o    (code_all),
      .fmt_err_o (fmt_err)
   );

   assign code_sel = code_all[blk_sel];
   assign is_trl   = (blk_sel == IDX_W'(TRL_IDX));

   acd_data_rules i_data (
      .code_i  (code_sel),
      .op_i    (op_req),
      .key_b_i (auth_key_b),
      .allow_o (dat_ok)
   );

   acd_trailer_rules i_trl (
      .code_i    (code_all[TRL_IDX]),
      .op_i      (op_req),
      .key_b_i   (auth_key_b),
      .allow_o   (trl_ok),
      .kb_open_o (kb_open)
   );

   assign kbx_c   = !fmt_err && kb_open;
   assign grant_c = !fmt_err && !(kbx_c && auth_key_b) && (is_trl ? trl_ok : dat_ok);

   if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            grant        <= 1'b0;
            fmt_bad      <= 1'b0;
            keyb_exposed <= 1'b0;
         end else begin
            grant        <= grant_c;
            fmt_bad      <= fmt_err;
            keyb_exposed <= kbx_c;
         end
      end
   end else begin : g_comb
      assign grant        = grant_c;
      assign fmt_bad      = fmt_err;
      assign keyb_exposed = kbx_c;
   end

endmodule

// File: rtl/acd_gate_chk.sv
module acd_gate_chk #(
   parameter int unsigned BLK_N   = 4,
   parameter int unsigned OP_W    = 4,
   parameter bit          REG_OUT = 1'b1,
   localparam int unsigned IDX_W  = $clog2(BLK_N)
) (
   input logic             clk,
   input logic             rst_n,
   input logic [IDX_W-1:0] blk_sel,
   input logic             auth_key_b,
   input logic [OP_W-1:0]  op_req,
   input logic             grant,
   input logic             fmt_bad,
   input logic             keyb_exposed
);

   localparam logic [IDX_W-1:0] TRL = IDX_W'(BLK_N - 1);

   logic [IDX_W-1:0] d_blk;
   logic             d_kb;
   logic [OP_W-1:0]  d_op;
   logic             vld;

   if (REG_OUT) begin : g_dly
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            d_blk <= '0;
            d_kb  <= 1'b0;
            d_op  <= '0;
            vld   <= 1'b0;
         end else begin
            d_blk <= blk_sel;
            d_kb  <= auth_key_b;
            d_op  <= op_req;
            vld   <= 1'b1;
         end
      end
   end else begin : g_nodly
      assign d_blk = blk_sel;
      assign d_kb  = auth_key_b;
      assign d_op  = op_req;
      assign vld   = 1'b1;
   end

   // R2
   fmt_blocks_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fmt_bad |-> !grant);

   // R8
   fmt_hides_keyb_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fmt_bad |-> !keyb_exposed);

   // R4
   ka_never_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (vld && d_blk == TRL && d_op == OP_W'(4)) |-> !grant);

   // R7
   trl_no_arith_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (vld && d_blk == TRL && d_op < OP_W'(4)) |-> !grant);

   // R7
   data_no_field_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (vld && d_blk != TRL && d_op >= OP_W'(4)) |-> !grant);

   // R8
   keyb_session_refused_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (vld && keyb_exposed && d_kb) |-> !grant);

endmodule

bind acd_gate acd_gate_chk #(.BLK_N(BLK_N), .OP_W(OP_W), .REG_OUT(REG_OUT)) i_acd_chk (.*);

// File: tb/test_acd_gate.sv
`timescale 1ns/1ps
module test_acd_gate;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [23:0] trl_acc = 24'h0;
   logic [1:0]  blk_sel = 2'd0;
   logic        auth_key_b = 1'b0;
   logic [3:0]  op_req = 4'd0;
   logic        grant, fmt_bad, keyb_exposed;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #2 clk = ~clk; // 250 MHz

   acd_gate i_acd_gate (
      .clk(clk), .rst_n(rst_n), .trl_acc(trl_acc), .blk_sel(blk_sel),
      .auth_key_b(auth_key_b), .op_req(op_req),
      .grant(grant), .fmt_bad(fmt_bad), .keyb_exposed(keyb_exposed)
   );

   // permission masks: 1 = key A, 2 = key B, 3 = either; index = c1*4+c2*2+c3
   localparam int DRD[8]  = '{3,3,3,2,3,2,3,0};
   localparam int DWR[8]  = '{3,0,0,2,2,0,2,0};
   localparam int DINC[8] = '{3,0,0,0,0,0,2,0};
   localparam int DDEC[8] = '{3,3,0,0,0,0,3,0};
   localparam int TKAW[8] = '{1,1,0,2,0,0,0,0};
   localparam int TACR[8] = '{1,1,1,3,3,3,3,3};
   localparam int TACW[8] = '{0,1,0,2,0,0,0,0};
   localparam int TKBR[8] = '{1,1,1,0,0,0,0,0};
   localparam int TKBW[8] = '{1,1,0,2,2,0,0,0};

   // R1 layout: byte8 = {c3,c2}, byte7 = {c1,~c3}, byte6 = {~c2,~c1}
   function automatic logic [23:0] mk_word(input int k0, input int k1, input int k2, input int k3);
      logic [3:0] c1, c2, c3;
      int k[4];
      k[0] = k0; k[1] = k1; k[2] = k2; k[3] = k3;
      for (int j = 0; j < 4; j++) begin
         c1[j] = k[j][2];
         c2[j] = k[j][1];
         c3[j] = k[j][0];
      end
      return {c3, c2, c1, ~c3, ~c2, ~c1};
   endfunction

   function automatic logic [2:0] ref_eval(input logic [23:0] a, input int blk, input bit kb, input int op);
      logic [7:0] b6, b7, b8;
      bit bad, kbr, g;
      int code, tcode, perm, mask;
      b6 = a[7:0]; b7 = a[15:8]; b8 = a[23:16];
      bad = 0;
      for (int j = 0; j < 4; j++) begin
         if (b7[4+j] == b6[j]) bad = 1;
         if (b8[j]   == b6[4+j]) bad = 1;
         if (b8[4+j] == b7[j]) bad = 1;
      end
      code  = b7[4+blk]*4 + b8[blk]*2 + b8[4+blk];
      tcode = b7[7]*4 + b8[3]*2 + b8[7];
      kbr   = !bad && (tcode <= 2);
      perm  = 0;
      if (blk != 3) begin
         case (op)
            0: perm = DRD[code];
            1: perm = DWR[code];
            2: perm = DINC[code];
            3: perm = DDEC[code];
            default: perm = 0;
         endcase
      end else begin
         case (op)
            5: perm = TKAW[code];
            6: perm = TACR[code];
            7: perm = TACW[code];
            8: perm = TKBR[code];
            9: perm = TKBW[code];
            default: perm = 0;
         endcase
      end
      mask = kb ? 2 : 1;
      g = !bad && !(kbr && kb) && ((perm & mask) != 0);
      return {g, bad, kbr};
   endfunction

   task automatic cmp(input logic [2:0] exp, input string tag);
      checks++;
      if ({grant, fmt_bad, keyb_exposed} !== exp) begin
         errors++;
         $display("FAIL %s: acc=%h blk=%0d keyB=%0d op=%0d got g/f/k=%b expected %b",
                  tag, trl_acc, blk_sel, auth_key_b, op_req,
                  {grant, fmt_bad, keyb_exposed}, exp);
      end
   endtask

   // called at a falling edge; returns at the next falling edge after comparing
   task automatic vec(input logic [23:0] a, input int blk, input bit kb, input int op, input string tag);
      logic [2:0] exp;
      trl_acc = a; blk_sel = blk[1:0]; auth_key_b = kb; op_req = op[3:0];
      exp = ref_eval(a, blk, kb, op);
      @(negedge clk);
      cmp(exp, tag);
   endtask

   initial begin
      logic [23:0] w;
      logic [2:0]  prev;
      // R10 reset state with a granting stimulus present
      trl_acc = 24'h8007FF; blk_sel = 2'd0; auth_key_b = 0; op_req = 4'd0;
      repeat (3) @(negedge clk);
      cmp(3'b000, "R10");
      rst_n = 1'b1;

      // R9 shipping word, every block / op / key
      for (int blk = 0; blk < 4; blk++)
         for (int op = 0; op < 10; op++)
            for (int kb = 0; kb < 2; kb++)
               vec(24'h8007FF, blk, kb[0], op, "R9");

      // R3 data table, trailer 011 keeps key B usable
      for (int c = 0; c < 8; c++)
         for (int blk = 0; blk < 3; blk++)
            for (int op = 0; op < 4; op++)
               for (int kb = 0; kb < 2; kb++)
                  vec(mk_word(c, c, c, 3), blk, kb[0], op, "R3");

      // R4 R5 R6 trailer fields
      for (int c = 0; c < 8; c++)
         for (int op = 4; op < 10; op++)
            for (int kb = 0; kb < 2; kb++)
               vec(mk_word(0, 0, 0, c), 3, kb[0], op,
                   (op < 6) ? "R4" : (op < 8) ? "R5" : "R6");

      // R7 wrong-type and reserved operations
      for (int op = 0; op < 16; op++)
         for (int kb = 0; kb < 2; kb++) begin
            vec(mk_word(0, 0, 0, 3), 3, kb[0], op, "R7");
            vec(mk_word(0, 0, 0, 3), 1, kb[0], op, "R7");
         end

      // R1 distinct code per block
      w = mk_word(1, 6, 5, 4);
      for (int blk = 0; blk < 4; blk++)
         for (int op = 0; op < 10; op++)
            for (int kb = 0; kb < 2; kb++)
               vec(w, blk, kb[0], op, "R1");

      // R2 single-bit corruption of every stored bit
      for (int i = 0; i < 24; i++)
         for (int kb = 0; kb < 2; kb++)
            vec(mk_word(0, 0, 0, 3) ^ (24'h1 << i), 0, kb[0], 0, "R2");

      // R8 exposure flag and key-B refusal, per trailer code
      for (int c = 0; c < 8; c++)
         for (int kb = 0; kb < 2; kb++) begin
            vec(mk_word(0, 0, 0, c), 2, kb[0], 0, "R8");
            vec(mk_word(0, 0, 0, c), 3, kb[0], 6, "R8");
         end

      // R10 outputs hold until the clock edge
      vec(24'h8007FF, 0, 0, 0, "R10");
      prev = {grant, fmt_bad, keyb_exposed};
      trl_acc = 24'h000000; op_req = 4'd7;
      #1;
      cmp(prev, "R10");
      @(negedge clk);
      cmp(3'b010, "R10");

      // mixed traffic
      for (int n = 0; n < 3000; n++) begin
         w = mk_word($urandom % 8, $urandom % 8, $urandom % 8, $urandom % 8);
         if (($urandom % 8) == 0) w = w ^ (24'h1 << ($urandom % 24));
         vec(w, $urandom % 4, $urandom % 2, $urandom % 16, "R3");
      end

      done = 1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: run hung, got no completion expected completion");
         $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule